// File: doc/BRIEF.md
# Palette Colour Loader with Pixel Lookup

This block keeps a 256-entry colour table. Each entry holds an 8-bit red, an 8-bit green and an 8-bit blue value. Software fills the table through two bus registers. An index register picks the entry to load. A colour data register takes component bytes that land in red, then green, then blue. After each blue byte the entry pointer moves to the next entry, so a whole table loads with one index write followed by a stream of data bytes.

A data write carries either one byte (bit lanes 7:0) or a full 32-bit word. A word is split into four bytes, and the most significant byte is used first. A word is consumed one byte per clock, and `bus_ready` stays low until the last byte is taken.

A separate scanout port turns an 8-bit pixel code into a packed 24-bit colour one cycle later. Every data write raises a redraw request that stays up until it is acknowledged.

Bus handshake rules:
- A transfer completes in the cycle where `bus_valid` and `bus_ready` are both high.
- While `bus_valid` is high and `bus_ready` is low, the master must hold the address, `bus_wide` and `bus_wdata` stable.
- The pixel port has no back-pressure. A pixel code presented with `pix_valid` always yields a result.

Top module: `palette_dac_seq`

## Requirements
- R1: After reset, every entry reads back as 24'h000000 on the lookup port, the component state is red, the entry pointer is 0, `rgb_valid` is low and `redraw_req` is low.
- R2: A write at offset 0x0 loads `bus_wdata[7:0]` as the entry pointer. The next data byte goes to the red component of that entry.
- R3: Data bytes at offset 0x4 fill red, then green, then blue of the current entry. After the blue byte the pointer increments by one and the state returns to red.
- R4: The pointer increment wraps from entry 255 to entry 0.
- R5: A data write with `bus_wide`=1 is handled as four component bytes in the order bits 31:24, 23:16, 15:8, 7:0, one per clock. `bus_ready` is low for the first three cycles of the transfer and high in the fourth.
- R6: A data write with `bus_wide`=0 uses `bus_wdata[7:0]` as one component byte and is accepted in its first cycle (`bus_ready` high). Index writes, reads and accesses to other offsets are also accepted in their first cycle.
- R7: `bus_rdata` is zero for every read. Writes to offsets other than 0x0 and 0x4 change neither the table nor the pointer nor the component state.
- R8: With `pix_valid` high in cycle N, `rgb_valid` is high in cycle N+1 and `rgb` = {red, green, blue} of entry `pix_idx`, in bits 23:16, 15:8 and 7:0. With `pix_valid` low, `rgb_valid` is low in the next cycle.
- R9: Each data byte sets `redraw_req` from the next cycle on. `redraw_ack` clears it, but a data byte in the same cycle as `redraw_ack` wins. Index writes do not set it.
- R10: An index write in the middle of an entry's three bytes restarts the sequence at red for the newly loaded entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request valid |
| bus_ready | output | 1 | Bus request accepted this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wide | input | 1 | 1 = 32-bit data write, 0 = single byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (always zero) |
| redraw_req | output | 1 | Sticky request to repaint after a table change |
| redraw_ack | input | 1 | Clears `redraw_req` |
| pix_valid | input | 1 | Pixel code valid |
| pix_idx | input | 8 | Pixel code to translate |
| rgb_valid | output | 1 | Colour result valid |
| rgb | output | 24 | Packed colour {red, green, blue} |

## Verification
Results fall due at three points:
- A byte written into the table is visible to a lookup started in the cycle after its handshake edge.
- A lookup's colour appears at the next clock edge.
- `redraw_req` rises at the edge that accepts a data byte.

Inputs are therefore driven on the falling edge and outputs are sampled one falling edge later. For wide writes the bench counts the falling edges with `bus_ready` low before the handshake and expects exactly three. The whole table is swept twice against a bench-side model of the pointer and component state: once after reset and once after loading.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    C_RED = 2'd0,
    C_GRN = 2'd1,
    C_BLU = 2'd2
  } comp_e;

  localparam int OFS_INDEX = 0;
  localparam int OFS_CMAP  = 4;
endpackage

// File: rtl/pal_unpack.sv
module pal_unpack #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_go,
  input  logic              narrow_go,
  input  logic [DATA_W-1:0] wdata,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_val,
  output logic              last
);
  localparam int NB = DATA_W / BYTE_W;
  localparam int CW = (NB > 1) ? $clog2(NB) : 1;

  logic [CW-1:0] cnt;

  assign last     = (cnt == CW'(NB - 1));
  assign byte_vld = wide_go | narrow_go;

  always_comb begin
    if (wide_go) byte_val = wdata[(NB - 1 - int'(cnt)) * BYTE_W +: BYTE_W];
    else         byte_val = wdata[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (wide_go) cnt <= last ? '0 : cnt + 1'b1;
  end

  // R5: a partially consumed word exists only while a wide write is being held
  p_cnt_needs_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $past(wide_go));
  // R5: one byte per clock while the word is not finished
  p_cnt_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_go && !last) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             byte_vld,
  output logic [IDX_W-1:0] cur_idx,
  output comp_e            cur_comp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx  <= '0;
      cur_comp <= C_RED;
    end else if (idx_wr) begin
      cur_idx  <= idx_val;
      cur_comp <= C_RED;
    end else if (byte_vld) begin
      case (cur_comp)
        C_RED:   cur_comp <= C_GRN;
        C_GRN:   cur_comp <= C_BLU;
        default: begin
          cur_comp <= C_RED;
          cur_idx  <= cur_idx + 1'b1;
        end
      endcase
    end
  end

  // R3, R4: blue byte returns to red and advances the pointer modulo the table size
  p_blue_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !idx_wr && cur_comp == C_BLU) |=>
      (cur_comp == C_RED && cur_idx == $past(cur_idx) + 1'b1));
  // R2, R10: an index write always restarts at red
  p_index_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (cur_comp == C_RED && cur_idx == $past(idx_val)));
  // R7: without bus activity the state holds
  p_state_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && !byte_vld) |=> ($stable(cur_idx) && $stable(cur_comp)));
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  comp_e             wr_comp,
  input  logic [COMP_W-1:0] wr_byte,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic              rgb_valid,
  output logic [3*COMP_W-1:0] rgb
);
  localparam int DEPTH = 1 << IDX_W;

  logic [COMP_W-1:0] red [DEPTH];
  logic [COMP_W-1:0] grn [DEPTH];
  logic [COMP_W-1:0] blu [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        red[e] <= '0;
        grn[e] <= '0;
        blu[e] <= '0;
      end else if (hit) begin
        if (wr_comp == C_RED) red[e] <= wr_byte;
        if (wr_comp == C_GRN) grn[e] <= wr_byte;
        if (wr_comp == C_BLU) blu[e] <= wr_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_valid <= 1'b0;
      rgb       <= '0;
    end else begin
      rgb_valid <= pix_valid;
      if (pix_valid) rgb <= {red[pix_idx], grn[pix_idx], blu[pix_idx]};
    end
  end

  // R8: one-cycle latency on the lookup port
  p_lookup_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> rgb_valid);
  p_lookup_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !rgb_valid);
endmodule

// File: rtl/palette_dac_seq.sv
module palette_dac_seq
  import pal_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  output logic                bus_ready,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wide,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                redraw_req,
  input  logic                redraw_ack,
  input  logic                pix_valid,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic                rgb_valid,
  output logic [3*COMP_W-1:0] rgb
);
  logic              wr_req, idx_wr, cmap_wr, wide_go, narrow_go;
  logic              byte_vld, last;
  logic [COMP_W-1:0] byte_val;
  logic [IDX_W-1:0]  cur_idx;
  comp_e             cur_comp;

  assign wr_req    = bus_valid && bus_write;
  assign idx_wr    = wr_req && (bus_addr == ADDR_W'(OFS_INDEX));
  assign cmap_wr   = wr_req && (bus_addr == ADDR_W'(OFS_CMAP));
  assign wide_go   = cmap_wr && bus_wide;
  assign narrow_go = cmap_wr && !bus_wide;
  assign bus_ready = !wide_go || last;
  assign bus_rdata = '0;

  pal_unpack #(.DATA_W(DATA_W), .BYTE_W(COMP_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .wide_go(wide_go), .narrow_go(narrow_go),
    .wdata(bus_wdata), .byte_vld(byte_vld), .byte_val(byte_val), .last(last)
  );

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_val(bus_wdata[IDX_W-1:0]),
    .byte_vld(byte_vld), .cur_idx(cur_idx), .cur_comp(cur_comp)
  );

  pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(byte_vld), .wr_idx(cur_idx),
    .wr_comp(cur_comp), .wr_byte(byte_val), .pix_valid(pix_valid),
    .pix_idx(pix_idx), .rgb_valid(rgb_valid), .rgb(rgb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          redraw_req <= 1'b0;
    else if (byte_vld)   redraw_req <= 1'b1;
    else if (redraw_ack) redraw_req <= 1'b0;
  end

  // R9: a data byte always leaves the redraw request raised
  p_redraw_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> redraw_req);
  // R9: the flag only rises after a data byte
  p_redraw_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redraw_req) |-> $past(byte_vld));
  // R7: reads return zero
  p_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |-> (bus_rdata == '0));
  // R6: a single-byte data write never stalls
  p_narrow_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_go |-> bus_ready);
endmodule

// File: tb/tb_palette_dac_seq.sv
module tb_palette_dac_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, redraw_req, rgb_valid;
  logic [31:0] bus_rdata;
  logic        redraw_ack = 1'b0, pix_valid = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic [23:0] rgb;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  int m_idx = 0, m_comp = 0;

  always #5 clk = ~clk;

  palette_dac_seq dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wide(bus_wide),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .redraw_req(redraw_req),
    .redraw_ack(redraw_ack), .pix_valid(pix_valid), .pix_idx(pix_idx),
    .rgb_valid(rgb_valid), .rgb(rgb)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_byte(input logic [7:0] v);
    case (m_comp)
      0: m_r[m_idx] = v;
      1: m_g[m_idx] = v;
      default: m_b[m_idx] = v;
    endcase
    if (m_comp == 2) begin m_comp = 0; m_idx = (m_idx + 1) % 256; end
    else m_comp++;
  endfunction

  task automatic bus_op(input logic wr, input logic [4:0] a, input logic wide,
                        input logic [31:0] d, output int waits, output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wide = wide; bus_wdata = d;
    waits = 0;
    #1;
    while (!bus_ready) begin @(negedge clk); #1; waits++; end
    rd = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    if (wr && a == 5'd0) begin m_idx = d[7:0]; m_comp = 0; end
    if (wr && a == 5'd4) begin
      if (wide) for (int k = 3; k >= 0; k--) model_byte(d[8*k +: 8]);
      else model_byte(d[7:0]);
    end
  endtask

  task automatic lookup(input int e, input string req);
    @(negedge clk);
    pix_valid = 1'b1; pix_idx = e[7:0];
    @(negedge clk);
    pix_valid = 1'b0;
    chk(rgb_valid === 1'b1, req, {31'd0, rgb_valid}, 32'd1);
    chk(rgb === {m_r[e], m_g[e], m_b[e]}, req, {8'd0, rgb}, {8'd0, m_r[e], m_g[e], m_b[e]});
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  initial begin
    int w;
    logic [31:0] rd;
    for (int e = 0; e < 256; e++) begin m_r[e] = 0; m_g[e] = 0; m_b[e] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rgb_valid === 1'b0, "R1", {31'd0, rgb_valid}, 32'd0);
    chk(redraw_req === 1'b0, "R1", {31'd0, redraw_req}, 32'd0);
    for (int e = 0; e < 256; e++) lookup(e, "R1");
    // R8: idle lookup leaves rgb_valid low
    @(negedge clk);
    chk(rgb_valid === 1'b0, "R8", {31'd0, rgb_valid}, 32'd0);

    // R2, R5: load whole table with wide words from entry 0
    bus_op(1'b1, 5'd0, 1'b0, 32'h0, w, rd);
    chk(redraw_req === 1'b0, "R9", {31'd0, redraw_req}, 32'd0);
    for (int q = 0; q < 192; q++) begin
      bus_op(1'b1, 5'd4, 1'b1, {pat(4*q), pat(4*q+1), pat(4*q+2), pat(4*q+3)}, w, rd);
      if (q < 4) chk(w == 3, "R5", w, 32'd3);
    end
    chk(m_idx == 0, "R4", m_idx, 0);
    chk(redraw_req === 1'b1, "R9", {31'd0, redraw_req}, 32'd1);
    for (int e = 0; e < 256; e++) lookup(e, "R3");

    // R9: ack clears; data byte in ack cycle wins
    @(negedge clk); redraw_ack = 1'b1;
    @(negedge clk); redraw_ack = 1'b0;
    chk(redraw_req === 1'b0, "R9", {31'd0, redraw_req}, 32'd0);
    redraw_ack = 1'b1;
    bus_op(1'b1, 5'd4, 1'b0, 32'hFFFF_FF5A, w, rd);
    redraw_ack = 1'b0;
    chk(redraw_req === 1'b1, "R9", {31'd0, redraw_req}, 32'd1);
    chk(w == 0, "R6", w, 0);
    lookup(0, "R6");

    // R4: wrap at 255 with narrow writes
    bus_op(1'b1, 5'd0, 1'b0, 32'h0000_12FF, w, rd);
    chk(w == 0, "R6", w, 0);
    for (int k = 0; k < 4; k++) bus_op(1'b1, 5'd4, 1'b0, 32'hAB00 | (k * 17 + 1), w, rd);
    lookup(255, "R4");
    lookup(0, "R4");

    // R10: restart mid-entry
    bus_op(1'b1, 5'd0, 1'b0, 32'd40, w, rd);
    bus_op(1'b1, 5'd4, 1'b0, 32'h11, w, rd);
    bus_op(1'b1, 5'd4, 1'b0, 32'h22, w, rd);
    bus_op(1'b1, 5'd0, 1'b0, 32'd41, w, rd);
    bus_op(1'b1, 5'd4, 1'b0, 32'h33, w, rd);
    lookup(40, "R10");
    lookup(41, "R10");

    // R7: reads return zero, other offsets ignored
    bus_op(1'b0, 5'd0, 1'b0, 32'd0, w, rd);
    chk(rd == 32'd0, "R7", rd, 0);
    bus_op(1'b0, 5'd4, 1'b0, 32'd0, w, rd);
    chk(rd == 32'd0, "R7", rd, 0);
    bus_op(1'b1, 5'd8, 1'b1, 32'hDEAD_BEEF, w, rd);
    chk(w == 0, "R6", w, 0);
    bus_op(1'b1, 5'd16, 1'b0, 32'h0000_0077, w, rd);
    bus_op(1'b1, 5'd4, 1'b0, 32'h44, w, rd);
    lookup(41, "R7");
    lookup(119, "R7");
    lookup(16, "R7");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule